// File: doc/BRIEF.md
# Programmable TDM Frame Sync Generator

This block generates the periodic frame sync of a time-division-multiplexed serial link. A bit clock, synchronous to the system clock and at most half its rate, is sampled every cycle. Its active edges drive a two-phase counter: the sync is high for one programmed number of active edges and low for another. A control bit picks the rising or the falling bit-clock transition as the active edge. A second control bit starts generation and gates the sync onto its output pin.

Software programs the block through a small write port with three addresses: control, high-phase width and low-phase width. A combinational read port returns what is stored. A width write that does not fit in the 11-bit width field is dropped, and the old value stays. New widths take effect only where one phase hands over to the next, so a running frame is never cut short.

Top module: `tdm_fsync_gen`

## Requirements
- R1: After synchronous reset, `fsync_out` is 0 and all three addresses read back 0.
- R2: A write of a value up to 0x7FF to address 1 (high width) or address 2 (low width) is stored and read back in bits 10:0, with the upper read bits 0.
- R3: A write above 0x7FF to address 1 or 2 is ignored, and the previously stored width reads back unchanged.
- R4: Address 0 holds the enable in bit 0 and the polarity in bit 1. Reading address 0 returns the enable in bit 0 and the polarity in bit 1, with the other bits 0. Writes to address 3 have no effect.
- R5: While the enable is 0, `fsync_out` is 0 and the phase counter is held at the start of the high phase. In the cycle after the enable is written to 1, `fsync_out` is 1.
- R6: Once enabled, a phase whose width value is N ends at its (N+1)-th active edge. The sync changes in the clock cycle after the cycle in which that edge is sampled, and alternates high then low.
- R7: With polarity 0, an active edge is a cycle where `bit_clk` reads 1 after reading 0 in the previous cycle. With polarity 1, it is a cycle where `bit_clk` reads 0 after reading 1.
- R8: A width written while generation runs is first used by the next phase of that kind that begins after the write. A phase already under way keeps its length.
- R9: A width value of 0 gives a phase of exactly one active edge, and 0x7FF gives 2048 active edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | TDM bit clock, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 high width, 2 low width |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| fsync_out | output | 1 | Frame sync output |

## Verification
The sync waveform is compared in every cycle against a model that counts the edges left in each phase. The bit clock is driven in three ways: a slow regular period, toggling on every cycle, and a pseudo-random level sequence. The slow and fast patterns separate correct edge counting from a counter that counts system cycles. The random pattern, run under both polarities, catches any mix-up between rising and falling edges. Width writes made in the middle of a phase, the extreme widths 0 and 0x7FF, out-of-range writes, and a disable and re-enable in mid-frame cover the boundary timing, the rejection path and the restart at the high phase.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_HIGH  = 2'd1,
        ADDR_LOW   = 2'd2,
        ADDR_SPARE = 2'd3
    } fsg_addr_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } fsg_phase_e;

    typedef struct packed {
        logic pol;   // 1: falling edge active, 0: rising edge active
        logic en;    // generation and output gate
    } fsg_ctrl_t;

    // active-edge decision from previous and current bit-clock samples
    function automatic logic edge_hit(input logic pol, input logic prev, input logic cur);
        return pol ? (prev & ~cur) : (~prev & cur);
    endfunction

    function automatic fsg_phase_e other_phase(input fsg_phase_e ph);
        return (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
    endfunction

endpackage

// File: rtl/fsg_regs.sv
module fsg_regs
    import fsg_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WIDTH_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output fsg_ctrl_t             ctrl,
    output logic [WIDTH_BITS-1:0] high_w,
    output logic [WIDTH_BITS-1:0] low_w
);
    localparam logic [DATA_W-1:0] MAX_VAL = DATA_W'((1 << WIDTH_BITS) - 1);
    localparam int PAD_W = DATA_W - WIDTH_BITS;

    logic fits;
    assign fits = (wr_data <= MAX_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            high_w <= '0;
            low_w  <= '0;
        end else if (wr_en) begin
            case (fsg_addr_e'(wr_addr))
                ADDR_CTRL: begin
                    ctrl.en  <= wr_data[0];
                    ctrl.pol <= wr_data[1];
                end
                ADDR_HIGH: if (fits) high_w <= wr_data[WIDTH_BITS-1:0];
                ADDR_LOW:  if (fits) low_w  <= wr_data[WIDTH_BITS-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (fsg_addr_e'(rd_addr))
            ADDR_CTRL: rd_data = {{(DATA_W-2){1'b0}}, ctrl.pol, ctrl.en};
            ADDR_HIGH: rd_data = {{PAD_W{1'b0}}, high_w};
            ADDR_LOW:  rd_data = {{PAD_W{1'b0}}, low_w};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fsg_edge.sv
module fsg_edge
    import fsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    input  logic pol,
    output logic tick
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= bit_clk;
    end

    assign tick = edge_hit(pol, prev_q, bit_clk);

endmodule

// File: rtl/fsg_phase.sv
module fsg_phase
    import fsg_pkg::*;
#(
    parameter int WIDTH_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  tick,
    input  logic [WIDTH_BITS-1:0] high_w,
    input  logic [WIDTH_BITS-1:0] low_w,
    output fsg_phase_e            phase,
    output logic [WIDTH_BITS-1:0] cnt,
    output logic [WIDTH_BITS-1:0] lim
);
    logic at_end;
    assign at_end = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= PH_HIGH;
            cnt   <= '0;
            lim   <= high_w;
        end else if (tick) begin
            if (at_end) begin
                phase <= other_phase(phase);
                cnt   <= '0;
                lim   <= (phase == PH_HIGH) ? low_w : high_w;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import fsg_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WIDTH_BITS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_clk,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fsync_out
);
    fsg_ctrl_t             ctrl;
    logic [WIDTH_BITS-1:0] high_w;
    logic [WIDTH_BITS-1:0] low_w;
    logic                  tick;
    fsg_phase_e            phase;
    logic [WIDTH_BITS-1:0] cnt_q;
    logic [WIDTH_BITS-1:0] lim_q;
    logic                  en_r;

    assign en_r = ctrl.en;

    fsg_regs #(.DATA_W(DATA_W), .WIDTH_BITS(WIDTH_BITS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(ctrl), .high_w(high_w), .low_w(low_w)
    );

    fsg_edge u_edge (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .pol(ctrl.pol), .tick(tick)
    );

    fsg_phase #(.WIDTH_BITS(WIDTH_BITS)) u_phase (
        .clk(clk), .rst(rst), .en(ctrl.en), .tick(tick), .high_w(high_w), .low_w(low_w),
        .phase(phase), .cnt(cnt_q), .lim(lim_q)
    );

    assign fsync_out = ctrl.en && (phase == PH_HIGH);

endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
    parameter int DATA_W     = 16,
    parameter int WIDTH_BITS = 11
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [1:0]            wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  fsync_out,
    input logic                  en_r,
    input logic                  tick,
    input logic [WIDTH_BITS-1:0] high_w,
    input logic [WIDTH_BITS-1:0] cnt_q,
    input logic [WIDTH_BITS-1:0] lim_q
);
    localparam logic [DATA_W-1:0] MAX_VAL = DATA_W'((1 << WIDTH_BITS) - 1);

    assert_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data > MAX_VAL) |=> $stable(high_w));

    assert_store_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data <= MAX_VAL)
        |=> (high_w == $past(wr_data[WIDTH_BITS-1:0])));

    assert_start_high_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(en_r) |-> fsync_out);

    assert_edge_only_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(wr_en && wr_addr == 2'd0)) |=> $stable(fsync_out));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);

endmodule

bind tdm_fsync_gen fsg_chk #(.DATA_W(DATA_W), .WIDTH_BITS(WIDTH_BITS)) u_fsg_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsync_out(fsync_out), .en_r(en_r), .tick(tick), .high_w(high_w),
    .cnt_q(cnt_q), .lim_q(lim_q)
);

// File: tb/tb_tdm_fsync_gen.sv
module tb_tdm_fsync_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        fsync_out;

    tdm_fsync_gen dut (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fsync_out(fsync_out)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    bit    cmp_on = 0;
    string cur_req = "R6";

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // bit clock stimulus: 0 hold, 1 regular half period, 2 pseudo-random level
    int        bmode = 0;
    int        half_p = 4;
    int        bcnt = 0;
    bit [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        if (bmode == 1) begin
            if (bcnt >= half_p - 1) begin
                bit_clk <= ~bit_clk;
                bcnt = 0;
            end else begin
                bcnt++;
            end
        end else if (bmode == 2) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bit_clk <= lfsr[0];
        end
    end

    // behavioural reference: edges remaining in the current phase
    bit m_prev, m_en, m_pol, m_high, edge_seen;
    int m_hw, m_lw, m_left;
    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_en = 0; m_pol = 0; m_hw = 0; m_lw = 0;
            m_high = 1; m_left = 1;
        end else begin
            edge_seen = m_pol ? (m_prev && !bit_clk) : (!m_prev && bit_clk);
            if (!m_en) begin
                m_high = 1;
                m_left = m_hw + 1;
            end else if (edge_seen) begin
                m_left--;
                if (m_left == 0) begin
                    m_high = !m_high;
                    m_left = m_high ? m_hw + 1 : m_lw + 1;
                end
            end
            m_prev = bit_clk;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_en = wr_data[0]; m_pol = wr_data[1]; end
                    2'd1: if (wr_data <= 16'h7FF) m_hw = int'(wr_data);
                    2'd2: if (wr_data <= 16'h7FF) m_lw = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) chk(cur_req, int'(fsync_out), int'(m_en && m_high));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        run(1);
        // R1 reset state
        chk("R1", int'(fsync_out), 0);
        rd_chk("R1", 2'd0, 0);
        rd_chk("R1", 2'd1, 0);
        rd_chk("R1", 2'd2, 0);
        cmp_on = 1;

        // R2 store and read back
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd5);
        rd_chk("R2", 2'd1, 3);
        rd_chk("R2", 2'd2, 5);

        // R3 out-of-range widths dropped
        wr(2'd1, 16'h0800);
        wr(2'd2, 16'hFFFF);
        rd_chk("R3", 2'd1, 3);
        rd_chk("R3", 2'd2, 5);

        // R4 spare address has no effect
        wr(2'd3, 16'hFFFF);
        rd_chk("R4", 2'd0, 0);
        rd_chk("R4", 2'd1, 3);
        chk("R4", int'(fsync_out), 0);

        // R5/R6/R7 enable with rising edges, slow regular bit clock
        bmode = 1; half_p = 4;
        cur_req = "R5";
        wr(2'd0, 16'd1);
        chk("R5", int'(fsync_out), 1);
        rd_chk("R4", 2'd0, 1);
        cur_req = "R6";
        run(300);

        // R8 width changes mid-run, R9 single-edge phase
        cur_req = "R8";
        wr(2'd2, 16'd2);
        run(20);
        wr(2'd1, 16'd0);
        cur_req = "R9";
        run(200);

        // R7 falling edge, fast toggling
        half_p = 1;
        cur_req = "R7";
        wr(2'd0, 16'd3);
        rd_chk("R4", 2'd0, 3);
        run(200);
        bmode = 2;
        run(600);
        wr(2'd0, 16'd1);
        run(600);

        // R5 disable mid-frame holds output low, restart at high
        wr(2'd1, 16'd4);
        cur_req = "R5";
        run(13);
        wr(2'd0, 16'd0);
        chk("R5", int'(fsync_out), 0);
        run(100);
        chk("R5", int'(fsync_out), 0);
        wr(2'd0, 16'd1);
        chk("R5", int'(fsync_out), 1);
        cur_req = "R6";
        run(400);

        // R9 maximum width, bit clock toggling each cycle
        bmode = 1; half_p = 1;
        wr(2'd1, 16'h07FF);
        wr(2'd2, 16'd1);
        rd_chk("R9", 2'd1, 16'h07FF);
        cur_req = "R9";
        run(9000);

        cmp_on = 0;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule